// File: doc/BRIEF.md
# Two-Channel PWM Burst Generator

This block drives two independent pulse-width outputs. Each channel has its own high duration, low duration and pulse budget. All three are measured in ticks of a shared timebase: a prescaler divides the system clock down to one tick per 100 microseconds. A command port carries an 8-bit code and a 16-bit argument. The codes program each channel's durations and budget, and one code writes an enable mask that covers both channels at once.

Enabling a channel starts it in the high phase. The channel then alternates between high and low for as long as it stays enabled. A non-zero pulse budget makes the channel stop on its own after that many high pulses. A budget of zero makes it run until the mask turns it off. A disabled channel holds its output low.

Top module: `pwm_burst_gen`

## Requirements
- R1: Out of reset both outputs and both enable bits are 0, every duration is 1 tick and every pulse budget is 0 (continuous).
- R2: While a channel is enabled, every high phase after the first lasts exactly its high count of ticks, and every low phase lasts exactly its low count of ticks. One tick is TICK_DIV clocks.
- R3: Writing 0 as a duration stores the value 1.
- R4: Channel n takes its high count from code 0x10+2n, its low count from code 0x11+2n and its pulse budget from code 0x14+n. Any other code apart from 0x1F changes nothing.
- R5: Code 0x1F with bit n of the argument cleared disables channel n. From the next cycle on, its output and enable are 0.
- R6: Code 0x1F with bit n set, sent while channel n is disabled, enables the channel. From the next cycle its output is high and a fresh burst begins.
- R7: With a budget N greater than 0, the channel produces exactly N high pulses. It clears its own enable bit on the tick that ends the Nth high phase.
- R8: With a budget of 0, the channel keeps running until the mask disables it.
- R9: If a mask write that sets bit n arrives on the same edge at which channel n would clear itself, the write wins: the channel stays enabled and restarts a fresh burst in the high phase.
- R10: The two channels are independent. Programming or running one leaves the other's output and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_code_i | input | 8 | Command code |
| cmd_data_i | input | 16 | Command argument |
| pwm_o | output | 2 | Channel outputs, bit n = channel n |
| en_o | output | 2 | Current enable state of each channel |

## Verification
A channel's self-clear at the end of its last pulse can coincide with a host write to the enable mask. The bench first lets a one-pulse burst finish, which shows where the tick edges fall. It then re-arms the channel so that the new pulse ends on a known tick, and lands a second mask write that sets the bit on exactly that edge. The check is that the enable bit and the output are both still high in the cycle after the collision, and that a later, undisturbed pulse does end the burst.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
  localparam int NUM_CH = 2;
  localparam int DUR_W  = 16;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_HI_BASE    = 8'h10;
  localparam logic [CODE_W-1:0] CODE_LO_BASE    = 8'h11;
  localparam logic [CODE_W-1:0] CODE_BUDGET_BASE = 8'h14;
  localparam logic [CODE_W-1:0] CODE_EN_MASK    = 8'h1F;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_burst_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [DUR_W-1:0]  cmd_data_i,
  output logic              pwm_o,
  output logic              en_o
);
  localparam logic [CODE_W-1:0] HI_CODE = CODE_HI_BASE + CODE_W'(2 * CH);
  localparam logic [CODE_W-1:0] LO_CODE = CODE_LO_BASE + CODE_W'(2 * CH);
  localparam logic [CODE_W-1:0] BU_CODE = CODE_BUDGET_BASE + CODE_W'(CH);
  localparam logic [DUR_W-1:0]  ONE     = DUR_W'(1);

  logic [DUR_W-1:0] hi_q, lo_q, budget_q, cnt_q, pulses_q;
  logic [DUR_W-1:0] wr_dur, cur_len;
  phase_e           phase_q;
  logic             en_q;
  logic             wr_hi, wr_lo, wr_bu, wr_mask;
  logic             phase_end, last_pulse, start, stop;

  assign wr_hi   = cmd_valid_i && (cmd_code_i == HI_CODE);
  assign wr_lo   = cmd_valid_i && (cmd_code_i == LO_CODE);
  assign wr_bu   = cmd_valid_i && (cmd_code_i == BU_CODE);
  assign wr_mask = cmd_valid_i && (cmd_code_i == CODE_EN_MASK);
  assign wr_dur  = (cmd_data_i == '0) ? ONE : cmd_data_i;

  assign cur_len    = (phase_q == PH_HIGH) ? hi_q : lo_q;
  assign phase_end  = en_q && tick_i && (cnt_q >= cur_len - ONE);
  assign last_pulse = phase_end && (phase_q == PH_HIGH) && (budget_q != '0)
                      && (pulses_q + ONE >= budget_q);
  // a set bit overrides the self-clear of the same edge
  assign start = wr_mask && cmd_data_i[CH] && (!en_q || last_pulse);
  assign stop  = wr_mask && !cmd_data_i[CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= ONE;
      lo_q     <= ONE;
      budget_q <= '0;
    end else begin
      if (wr_hi) hi_q     <= wr_dur;
      if (wr_lo) lo_q     <= wr_dur;
      if (wr_bu) budget_q <= cmd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      phase_q  <= PH_LOW;
      cnt_q    <= '0;
      pulses_q <= '0;
    end else if (start) begin
      en_q     <= 1'b1;
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      pulses_q <= '0;
    end else if (stop || last_pulse) begin
      en_q    <= 1'b0;
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (en_q && tick_i) begin
      if (phase_end) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        if (phase_q == PH_HIGH) pulses_q <= pulses_q + ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign en_o  = en_q;
  assign pwm_o = en_q && (phase_q == PH_HIGH);
endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_burst_pkg::*;
#(
  parameter int TICK_DIV = 25000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [DUR_W-1:0]  cmd_data_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] en_o
);
  logic tick;

  pwm_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pwm_chan #(.CH(n)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .cmd_valid_i (cmd_valid_i),
      .cmd_code_i  (cmd_code_i),
      .cmd_data_i  (cmd_data_i),
      .pwm_o       (pwm_o[n]),
      .en_o        (en_o[n])
    );
  end
endmodule

// File: rtl/pwm_burst_chk.sv
module pwm_burst_chk
  import pwm_burst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [CODE_W-1:0] cmd_code_i,
  input logic [DUR_W-1:0]  cmd_data_i,
  input logic              tick_i,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] en_i
);
  logic mask_wr;
  assign mask_wr = cmd_valid_i && (cmd_code_i == CODE_EN_MASK);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R5
    mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_wr && !cmd_data_i[n]) |=> (!en_i[n] && !pwm_i[n]));
    // R6
    arm_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_wr && cmd_data_i[n] && !en_i[n]) |=> (en_i[n] && pwm_i[n]));
    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_wr && cmd_data_i[n]) |=> en_i[n]);
    // R2
    tick_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[n] && $past(en_i[n]) && (pwm_i[n] != $past(pwm_i[n]))) |-> $past(tick_i));
    // R7
    self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(en_i[n]) && !$past(mask_wr)) |-> ($past(pwm_i[n]) && $past(tick_i)));
  end
endmodule

bind pwm_burst_gen pwm_burst_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_code_i  (cmd_code_i),
  .cmd_data_i  (cmd_data_i),
  .tick_i      (tick),
  .pwm_i       (pwm_o),
  .en_i        (en_o)
);

// File: tb/pwm_burst_gen_bench.sv
`timescale 1ns/1ps
module pwm_burst_gen_bench;
  localparam int DIV = 4;

  typedef struct packed {
    logic        ch;
    logic [15:0] hi, lo, budget, ehi, elo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd3, 16'd2, 16'd4, 16'd3, 16'd2},
    '{1'b1, 16'd1, 16'd5, 16'd2, 16'd1, 16'd5},
    '{1'b0, 16'd0, 16'd0, 16'd3, 16'd1, 16'd1},
    '{1'b1, 16'd7, 16'd1, 16'd1, 16'd7, 16'd1},
    '{1'b0, 16'd2, 16'd3, 16'd0, 16'd2, 16'd3},
    '{1'b1, 16'd0, 16'd4, 16'd0, 16'd1, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [15:0] cmd_data = '0;
  logic [1:0]  pwm, en;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  int exp_hi [2];
  int exp_lo [2];
  int rises [2];
  int wbad [2];
  int run [2];
  logic prev [2];
  logic fresh [2];
  logic low_ok [2];

  always #2 clk = ~clk;

  pwm_burst_gen #(.TICK_DIV(DIV)) u_pwm_burst_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_code_i  (cmd_code),
    .cmd_data_i  (cmd_data),
    .pwm_o       (pwm),
    .en_o        (en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int c = 0; c < 2; c++) begin
      rises[c] = 0; wbad[c] = 0; run[c] = 0;
      prev[c] = 1'b0; fresh[c] = 1'b1; low_ok[c] = 1'b0;
    end
  end

  // width monitor: first high after enable and phases cut by disable are skipped
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (pwm[c] == prev[c]) run[c] = run[c] + 1;
      else begin
        if (prev[c]) begin
          if (en[c] && !fresh[c] && run[c] != exp_hi[c] * DIV) begin
            wbad[c] = wbad[c] + 1;
            $display("width mismatch ch%0d high=%0d exp=%0d", c, run[c], exp_hi[c] * DIV);
          end
          fresh[c] = 1'b0;
          low_ok[c] = en[c];
        end else begin
          rises[c] = rises[c] + 1;
          if (low_ok[c] && run[c] != exp_lo[c] * DIV) begin
            wbad[c] = wbad[c] + 1;
            $display("width mismatch ch%0d low=%0d exp=%0d", c, run[c], exp_lo[c] * DIV);
          end
        end
        run[c] = 1;
      end
      if (!en[c]) begin
        fresh[c] = 1'b1;
        low_ok[c] = 1'b0;
      end
      prev[c] = pwm[c];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] code, input logic [15:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; cmd_data = '0;
  endtask

  task automatic setup(input int c, input logic [15:0] hi, input logic [15:0] lo,
                       input logic [15:0] bu, input int ehi, input int elo);
    exp_hi[c] = ehi; exp_lo[c] = elo;
    cmd(8'h10 + 8'(2 * c), hi);
    cmd(8'h11 + 8'(2 * c), lo);
    cmd(8'h14 + 8'(c), bu);
  endtask

  task automatic wait_off(input int c, input int limit);
    for (int k = 0; k < limit && en[c]; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int r0, w0, w1;
    int e_cyc;
    exp_hi[0] = 1; exp_lo[0] = 1; exp_hi[1] = 1; exp_lo[1] = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pwm == 2'b00, "R1 pwm after reset", pwm, 0);
    chk(en == 2'b00, "R1 en after reset", en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: default durations 1/1 and continuous budget
    w0 = wbad[0]; r0 = rises[0];
    cmd(8'h1F, 16'h0001);
    chk(pwm[0] == 1'b1, "R6 high after enable", pwm[0], 1);
    // R4: foreign codes change nothing
    cmd(8'h16, 16'hFFFF);
    cmd(8'h1E, 16'hFFFF);
    repeat (40) @(negedge clk);
    chk(en == 2'b01, "R4 foreign codes ignored en", en, 1);
    chk(wbad[0] == w0, "R1 default widths", wbad[0] - w0, 0);
    chk(rises[0] - r0 >= 5, "R1 default continuous pulses", rises[0] - r0, 5);
    cmd(8'h1F, 16'h0000);
    chk(pwm[0] == 1'b0 && en[0] == 1'b0, "R5 disable", {en[0], pwm[0]}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      int c;
      c = int'(VECS[i].ch);
      setup(c, VECS[i].hi, VECS[i].lo, VECS[i].budget, int'(VECS[i].ehi), int'(VECS[i].elo));
      w0 = wbad[c]; r0 = rises[c];
      cmd(8'h1F, 16'(1 << c));
      chk(pwm[c] == 1'b1, "R6 vector start high", pwm[c], 1);
      chk(en[1 - c] == 1'b0 && pwm[1 - c] == 1'b0, "R10 idle channel untouched",
          {en[1 - c], pwm[1 - c]}, 0);
      if (VECS[i].budget != 0) begin
        wait_off(c, 3000);
        chk(en[c] == 1'b0, "R7 burst self clear", en[c], 0);
        chk(rises[c] - r0 == int'(VECS[i].budget), "R7 pulse count",
            rises[c] - r0, int'(VECS[i].budget));
      end else begin
        int per;
        per = (int'(VECS[i].ehi) + int'(VECS[i].elo)) * DIV;
        repeat (300) @(negedge clk);
        chk(en[c] == 1'b1, "R8 continuous still enabled", en[c], 1);
        chk(rises[c] - r0 >= 300 / per, "R8 continuous pulses", rises[c] - r0, 300 / per);
        cmd(8'h1F, 16'h0000);
        chk(pwm[c] == 1'b0 && en[c] == 1'b0, "R5 vector disable", {en[c], pwm[c]}, 0);
      end
      // R2 and R3 (zero durations in vectors 2 and 5)
      chk(wbad[c] == w0, "R2 R3 phase widths", wbad[c] - w0, 0);
    end

    // R10: both channels at once, one bursting, one continuous
    setup(0, 16'd2, 16'd2, 16'd0, 2, 2);
    setup(1, 16'd1, 16'd3, 16'd2, 1, 3);
    w0 = wbad[0]; w1 = wbad[1]; r0 = rises[1];
    cmd(8'h1F, 16'h0003);
    chk(pwm == 2'b11, "R10 both start high", pwm, 3);
    wait_off(1, 2000);
    chk(en == 2'b01, "R10 ch0 keeps running after ch1 burst", en, 1);
    chk(rises[1] - r0 == 2, "R10 ch1 burst count", rises[1] - r0, 2);
    chk(wbad[0] == w0 && wbad[1] == w1, "R10 widths with both running",
        wbad[0] - w0 + wbad[1] - w1, 0);
    cmd(8'h1F, 16'h0000);

    // R9: mask set lands on the self-clear edge
    setup(0, 16'd1, 16'd1, 16'd1, 1, 1);
    cmd(8'h1F, 16'h0001);
    wait_off(0, 100);
    e_cyc = cyc;                // self-clear happened on a tick edge
    cmd(8'h1F, 16'h0001);       // lands on edge e_cyc+2
    cmd(8'h1F, 16'h0001);       // lands on edge e_cyc+4, a tick edge
    chk(cyc == e_cyc + 4, "R9 bench alignment", cyc, e_cyc + 4);
    chk(en[0] == 1'b1, "R9 enable survives collision", en[0], 1);
    chk(pwm[0] == 1'b1, "R9 restart in high phase", pwm[0], 1);
    wait_off(0, 100);
    chk(en[0] == 1'b0, "R9 restarted burst ends", en[0], 0);

    summary();
  end
endmodule